// File: doc/BRIEF.md
# PWM-Locked Control Event Scheduler

This block turns the extremum strobes of a triangular PWM carrier into periodic control events. A mode field picks which extrema count: the carrier's low turning points, its high turning points, or both. The block counts the qualifying extrema and divides them by a programmable integer ratio. Each time the count completes, it issues one control trigger and a set of sensor sample-start pulses in the same clock cycle. Feedback capture and control execution therefore stay aligned to the switching pattern.

Each sensor port has its own enable bit, and only enabled sensors receive a pulse. A sticky pending flag records that an event has happened until a write-one-to-clear strobe removes it. A global enable parks the block: while it is low, the extremum counter is held at zero and no outputs are produced.

Top module: `pwm_event_sched`

## Requirements
- R1: During reset, and on the first cycle after it, `trigger`, `sample_start` and `event_pending` are 0. The ratio register resets to 1.
- R2: With `mode` = 2'b00, only `valley_strobe` pulses are counted, and `peak_strobe` pulses have no effect on any output.
- R3: With `mode` = 2'b01, only `peak_strobe` pulses are counted, and `valley_strobe` pulses have no effect on any output.
- R4: With `mode` = 2'b10, both kinds of strobe are counted. The reserved code 2'b11 behaves exactly like 2'b00 (valley only).
- R5: With ratio N, an event occurs on the Nth qualifying extremum and then on every Nth one after it.
- R6: A ratio value of 0 behaves as 1, so every qualifying extremum produces an event.
- R7: A pulse on `ratio_wr` loads `ratio_wdata` and clears the extremum count. A strobe in the same cycle as the write is not counted, so the next event needs a full N new extrema.
- R8: `trigger` rises at the clock edge that samples the event-completing strobe and stays high for exactly one cycle.
- R9: `sample_start` equals `sensor_en` (bit i for sensor i) in the cycle `trigger` is high, and is 0 in every other cycle.
- R10: `event_pending` is set by each event and stays set until a `pending_clr` pulse clears it. If an event and a clear happen in the same cycle, the flag ends up set.
- R11: While `enable` is low, the extremum count is held at zero, no trigger or sample pulse is produced, and `event_pending` is cleared. After `enable` returns high, counting starts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Global enable; low parks the block |
| mode | input | 2 | Qualifying extremum: 00 valley, 01 peak, 10 both, 11 valley |
| peak_strobe | input | 1 | One-cycle pulse at the carrier maximum |
| valley_strobe | input | 1 | One-cycle pulse at the carrier minimum |
| ratio_wdata | input | 16 | New divide ratio |
| ratio_wr | input | 1 | Write strobe for the ratio register |
| sensor_en | input | 8 | Per-sensor sample enable mask |
| pending_clr | input | 1 | Write-one-to-clear strobe for the pending flag |
| trigger | output | 1 | One-cycle control event pulse |
| sample_start | output | 8 | Per-sensor sample-start pulses |
| event_pending | output | 1 | Sticky event flag |

## Verification
The divider is exercised with ratios of 0, 1, 2 and 3. Each strobe's outcome is compared with its position in the count, which separates an off-by-one in the terminal value from a count that does not wrap. Strobes of the wrong kind are mixed in under every mode code, so a mode decode error shows up as a missing or extra trigger. Ratio writes are placed in the middle of a count and on the same cycle as a strobe, which shows whether the count restarts and whether the collided strobe is dropped. The enable, mask and clear inputs are toggled around events, so gating mistakes show at the pins.

// File: rtl/pwm_event_pkg.sv
// Shared definitions for the PWM-locked event scheduler.
// Assumes: the mode field is two bits wide.
package pwm_event_pkg;
    typedef enum logic [1:0] {
        EXT_VALLEY   = 2'b00,
        EXT_PEAK     = 2'b01,
        EXT_BOTH     = 2'b10,
        EXT_RESERVED = 2'b11
    } ext_mode_e;
endpackage

// File: rtl/pwm_extremum_sel.sv
// Picks which carrier extremum strobes count toward the next event.
// Assumes: strobes are single-cycle pulses; the reserved code acts as valley.
module pwm_extremum_sel
    import pwm_event_pkg::*;
(
    input  logic       peak_strobe,
    input  logic       valley_strobe,
    input  ext_mode_e  mode,
    output logic       qual
);
    // Decode the mode into a single qualifying pulse.
    always_comb begin
        case (mode)
            EXT_PEAK: qual = peak_strobe;
            EXT_BOTH: qual = peak_strobe | valley_strobe;
            default:  qual = valley_strobe;
        endcase
    end
endmodule

// File: rtl/pwm_ratio_div.sv
// Holds the divide ratio and counts qualifying extrema; flags the one that completes a group of N.
// Assumes: a ratio of 0 means 1; a ratio write restarts the count and drops a coincident strobe.
module pwm_ratio_div #(
    parameter int RATIO_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic               qual,
    input  logic [RATIO_W-1:0] ratio_wdata,
    input  logic               ratio_wr,
    output logic               event_hit
);
    localparam logic [RATIO_W-1:0] RATIO_RST = RATIO_W'(1);

    logic [RATIO_W-1:0] ratio_q;
    logic [RATIO_W-1:0] cnt_q;
    logic [RATIO_W-1:0] limit;

    // Terminal count: ratio minus one, with zero folded onto one.
    assign limit = (ratio_q == '0) ? '0 : ratio_q - RATIO_W'(1);

    // Event fires on the strobe that reaches the terminal count.
    assign event_hit = enable && !ratio_wr && qual && (cnt_q >= limit);

    // Ratio register, loaded by the write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)        ratio_q <= RATIO_RST;
        else if (ratio_wr) ratio_q <= ratio_wdata;
    end

    // Extremum counter: held while disabled, restarted on a ratio write, wraps at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) cnt_q <= '0;
        else if (ratio_wr)     cnt_q <= '0;
        else if (qual)         cnt_q <= (cnt_q >= limit) ? '0 : cnt_q + RATIO_W'(1);
    end

    // R5
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= limit);

    // R7
    wr_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ratio_wr |=> cnt_q == '0);

    // R11
    hold_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> cnt_q == '0);
endmodule

// File: rtl/pwm_event_out.sv
// Registers the event into the trigger, the gated sensor pulses and the sticky pending flag.
// Assumes: event_hit is already qualified by the global enable.
module pwm_event_out #(
    parameter int NUM_SENSORS = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   enable,
    input  logic                   event_hit,
    input  logic [NUM_SENSORS-1:0] sensor_en,
    input  logic                   pending_clr,
    output logic                   trigger,
    output logic [NUM_SENSORS-1:0] sample_start,
    output logic                   event_pending
);
    // One-cycle trigger pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) trigger <= 1'b0;
        else        trigger <= event_hit;
    end

    // One sample-start flop per sensor, gated by that sensor's enable bit.
    for (genvar s = 0; s < NUM_SENSORS; s++) begin : g_sensor
        always_ff @(posedge clk) begin
            if (!rst_n) sample_start[s] <= 1'b0;
            else        sample_start[s] <= event_hit & sensor_en[s];
        end
    end

    // Sticky flag: the set wins over a coincident clear; cleared while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) event_pending <= 1'b0;
        else if (event_hit)    event_pending <= 1'b1;
        else if (pending_clr)  event_pending <= 1'b0;
    end

    // R9
    mask_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        event_hit |=> sample_start == $past(sensor_en));

    // R10
    pending_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trigger |-> event_pending);

    // R10
    pending_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pending_clr && !event_hit) |=> !event_pending);

    // R11
    quiet_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!trigger && sample_start == '0 && !event_pending));
endmodule

// File: rtl/pwm_event_sched.sv
// Top level: selects carrier extrema, divides them by the ratio and issues the synchronized
// control trigger and sensor sample pulses.
// Assumes: strobes and write strobes are single-cycle pulses in the clk domain.
module pwm_event_sched
    import pwm_event_pkg::*;
#(
    parameter int RATIO_W     = 16,
    parameter int NUM_SENSORS = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   enable,
    input  logic [1:0]             mode,
    input  logic                   peak_strobe,
    input  logic                   valley_strobe,
    input  logic [RATIO_W-1:0]     ratio_wdata,
    input  logic                   ratio_wr,
    input  logic [NUM_SENSORS-1:0] sensor_en,
    input  logic                   pending_clr,
    output logic                   trigger,
    output logic [NUM_SENSORS-1:0] sample_start,
    output logic                   event_pending
);
    logic qual;
    logic event_hit;

    pwm_extremum_sel u_sel (
        .peak_strobe   (peak_strobe),
        .valley_strobe (valley_strobe),
        .mode          (ext_mode_e'(mode)),
        .qual          (qual)
    );

    pwm_ratio_div #(.RATIO_W(RATIO_W)) u_div (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .qual        (qual),
        .ratio_wdata (ratio_wdata),
        .ratio_wr    (ratio_wr),
        .event_hit   (event_hit)
    );

    pwm_event_out #(.NUM_SENSORS(NUM_SENSORS)) u_out (
        .clk           (clk),
        .rst_n         (rst_n),
        .enable        (enable),
        .event_hit     (event_hit),
        .sensor_en     (sensor_en),
        .pending_clr   (pending_clr),
        .trigger       (trigger),
        .sample_start  (sample_start),
        .event_pending (event_pending)
    );

    // R8
    trig_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!peak_strobe && !valley_strobe) |=> !trigger);
endmodule

// File: tb/pwm_event_sched_tb.sv
// Directed bench for pwm_event_sched: one task per scenario, each checking its own results.
module pwm_event_sched_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic [1:0] mode = 2'b00;
    logic       peak_strobe = 1'b0;
    logic       valley_strobe = 1'b0;
    logic [15:0] ratio_wdata = '0;
    logic       ratio_wr = 1'b0;
    logic [7:0] sensor_en = 8'h00;
    logic       pending_clr = 1'b0;
    logic       trigger;
    logic [7:0] sample_start;
    logic       event_pending;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_event_sched dut_i (
        .clk(clk), .rst_n(rst_n), .enable(enable), .mode(mode),
        .peak_strobe(peak_strobe), .valley_strobe(valley_strobe),
        .ratio_wdata(ratio_wdata), .ratio_wr(ratio_wr), .sensor_en(sensor_en),
        .pending_clr(pending_clr), .trigger(trigger), .sample_start(sample_start),
        .event_pending(event_pending)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive one strobe cycle, then return at the negedge where its registered result shows.
    task automatic strobe(input logic p, input logic v);
        @(negedge clk);
        peak_strobe = p; valley_strobe = v;
        @(negedge clk);
        peak_strobe = 1'b0; valley_strobe = 1'b0;
    endtask

    task automatic write_ratio(input logic [15:0] val);
        @(negedge clk);
        ratio_wdata = val; ratio_wr = 1'b1;
        @(negedge clk);
        ratio_wr = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 trigger", {31'd0, trigger}, 0);
        chk("R1 sample_start", {24'd0, sample_start}, 0);
        chk("R1 pending", {31'd0, event_pending}, 0);
        enable = 1'b1; mode = 2'b00;
        strobe(1'b0, 1'b1);  // reset ratio of 1 fires on the first valley
        chk("R1 ratio default 1", {31'd0, trigger}, 1);
        @(negedge clk);
        chk("R8 trigger one cycle", {31'd0, trigger}, 0);
    endtask

    task automatic t_valley_mode();
        mode = 2'b00; write_ratio(16'd1);
        strobe(1'b1, 1'b0);
        chk("R2 peak ignored", {31'd0, trigger}, 0);
        strobe(1'b0, 1'b1);
        chk("R2 valley counted", {31'd0, trigger}, 1);
    endtask

    task automatic t_peak_mode();
        mode = 2'b01; write_ratio(16'd1);
        strobe(1'b0, 1'b1);
        chk("R3 valley ignored", {31'd0, trigger}, 0);
        strobe(1'b1, 1'b0);
        chk("R3 peak counted", {31'd0, trigger}, 1);
    endtask

    task automatic t_both_mode();
        mode = 2'b10; write_ratio(16'd2);
        strobe(1'b1, 1'b0);
        chk("R4 both first", {31'd0, trigger}, 0);
        strobe(1'b0, 1'b1);
        chk("R4 both second", {31'd0, trigger}, 1);
        mode = 2'b11; write_ratio(16'd1);
        strobe(1'b1, 1'b0);
        chk("R4 reserved peak ignored", {31'd0, trigger}, 0);
        strobe(1'b0, 1'b1);
        chk("R4 reserved valley counted", {31'd0, trigger}, 1);
    endtask

    task automatic t_ratio3();
        mode = 2'b00; write_ratio(16'd3);
        for (int i = 0; i < 7; i++) begin
            strobe(1'b0, 1'b1);
            chk("R5 divide by 3", {31'd0, trigger}, (i % 3 == 2) ? 1 : 0);
        end
    endtask

    task automatic t_ratio0();
        mode = 2'b00; write_ratio(16'd0);
        for (int i = 0; i < 3; i++) begin
            strobe(1'b0, 1'b1);
            chk("R6 zero acts as one", {31'd0, trigger}, 1);
        end
    endtask

    task automatic t_rewrite();
        mode = 2'b00; write_ratio(16'd3);
        strobe(1'b0, 1'b1); strobe(1'b0, 1'b1);
        write_ratio(16'd3);
        strobe(1'b0, 1'b1);
        chk("R7 restart a", {31'd0, trigger}, 0);
        strobe(1'b0, 1'b1);
        chk("R7 restart b", {31'd0, trigger}, 0);
        // write coincident with a strobe: the strobe is dropped
        @(negedge clk);
        ratio_wdata = 16'd2; ratio_wr = 1'b1; valley_strobe = 1'b1;
        @(negedge clk);
        ratio_wr = 1'b0; valley_strobe = 1'b0;
        chk("R7 coincident no event", {31'd0, trigger}, 0);
        strobe(1'b0, 1'b1);
        chk("R7 coincident dropped", {31'd0, trigger}, 0);
        strobe(1'b0, 1'b1);
        chk("R7 full N after write", {31'd0, trigger}, 1);
    endtask

    task automatic t_mask();
        mode = 2'b00; write_ratio(16'd2); sensor_en = 8'hA5;
        strobe(1'b0, 1'b1);
        chk("R9 no event no samples", {24'd0, sample_start}, 0);
        strobe(1'b0, 1'b1);
        chk("R9 mask on event", {24'd0, sample_start}, 32'hA5);
        @(negedge clk);
        chk("R9 samples one cycle", {24'd0, sample_start}, 0);
        sensor_en = 8'h00;
        strobe(1'b0, 1'b1); strobe(1'b0, 1'b1);
        chk("R9 empty mask trigger", {31'd0, trigger}, 1);
        chk("R9 empty mask samples", {24'd0, sample_start}, 0);
    endtask

    task automatic t_pending();
        mode = 2'b00; write_ratio(16'd1);
        @(negedge clk); pending_clr = 1'b1; @(negedge clk); pending_clr = 1'b0;
        chk("R10 cleared", {31'd0, event_pending}, 0);
        strobe(1'b0, 1'b1);
        chk("R10 set", {31'd0, event_pending}, 1);
        repeat (3) @(negedge clk);
        chk("R10 sticky", {31'd0, event_pending}, 1);
        @(negedge clk);
        pending_clr = 1'b1; valley_strobe = 1'b1;
        @(negedge clk);
        pending_clr = 1'b0; valley_strobe = 1'b0;
        chk("R10 set wins", {31'd0, event_pending}, 1);
        @(negedge clk); pending_clr = 1'b1; @(negedge clk); pending_clr = 1'b0;
        chk("R10 clear", {31'd0, event_pending}, 0);
    endtask

    task automatic t_enable();
        mode = 2'b00; write_ratio(16'd1); sensor_en = 8'hFF;
        strobe(1'b0, 1'b1);
        chk("R11 pending before", {31'd0, event_pending}, 1);
        enable = 1'b0;
        strobe(1'b0, 1'b1);
        chk("R11 no trigger off", {31'd0, trigger}, 0);
        chk("R11 no samples off", {24'd0, sample_start}, 0);
        chk("R11 pending cleared", {31'd0, event_pending}, 0);
        enable = 1'b1; write_ratio(16'd2);
        strobe(1'b0, 1'b1);
        enable = 1'b0; @(negedge clk); enable = 1'b1;
        strobe(1'b0, 1'b1);
        chk("R11 count restarted", {31'd0, trigger}, 0);
        strobe(1'b0, 1'b1);
        chk("R11 counting resumes", {31'd0, trigger}, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_valley_mode();
        t_peak_mode();
        t_both_mode();
        t_ratio3();
        t_ratio0();
        t_rewrite();
        t_mask();
        t_pending();
        t_enable();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule